// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Voltage-Output DAC

This block connects a single-channel voltage-output DAC to a two-wire (I2C-compatible) serial bus. The block is a bus slave and never drives the clock. It oversamples SCL and SDA on a faster system clock and finds start and stop conditions. It answers one 7-bit address, part of which comes from pins. It acknowledges the bytes it takes, and it drives SDA only through an open-drain enable that pulls the line low.

A write places pairs of data bytes after the address. Each pair forms a 16-bit command word. In that word, bits 15:14 are ignored, bits 13:12 choose the power mode, and the DAC code sits left-justified from bit 11 downward. Every full pair updates the code and mode outputs and pulses a one-cycle strobe, so one addressing phase can carry many updates. A read returns the current command word, high byte first, until the master declines a byte.

The resolution is 8, 10 or 12 bits, set by `DAC_BITS`. A reduced-pin variant, set by `NARROW_ADDR`, fixes six address bits instead of five.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset, `dac_code` and `pd_mode` are zero, and `sda_oe` and `update_stb` are low.
- R2: The device address is {00011, addr_pins[1], addr_pins[0]}. When `NARROW_ADDR` is set, it is {000110, addr_pins[0]}. The address goes MSB first and is followed by a direction bit (1 = master reads). On a match the block pulls SDA low during the ninth SCL pulse.
- R3: A byte after a start whose address does not match gets no acknowledge. The block then ignores all bus traffic until the next start, and its outputs do not change.
- R4: During a write, every data byte is acknowledged. A byte pair forms word W (first byte = W[15:8]). `pd_mode` takes W[13:12] and `dac_code` takes W[11:12-DAC_BITS]. W[15:14] and the bits below the code are ignored.
- R5: Every complete pair in one transaction updates the outputs and raises `update_stb` for exactly one cycle. This happens in the same cycle the outputs change and in no other cycle.
- R6: If a stop or a repeated start follows a single data byte, that byte is discarded and no output changes. The next pair starts afresh.
- R7: A read returns the word {00, pd_mode, dac_code left-justified, zeros}, MSB first, with the high byte first.
- R8: In a read, a master ACK makes the block send the other byte next (low after high, high after low). A NACK makes the block release SDA and stay off the bus until the next start.
- R9: `sda_oe` is raised only while the synchronized SCL is low. SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus is oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pins | input | 2 | Pin-selected low address bits |
| dac_code | output | DAC_BITS | Current DAC code |
| pd_mode | output | 2 | Power mode: 00 normal, others power-down |
| update_stb | output | 1 | One-cycle pulse on each output update |

## Verification
On every cycle, the assertions check three things. Outputs change only with the strobe, and the strobe is single-cycle and follows a delivered data byte. The open-drain enable only rises while SCL is low and stays off in the ignore state. The bench's scenarios are needed for the rest: acknowledge placement on the bus, address matching, byte-pair assembly and the ignored fields, discard of half pairs on stop and repeated start, and the byte order of reads with ACK/NACK. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a start
    S_RX,     // shifting in a byte
    S_ACK,    // holding SDA low for the ninth pulse
    S_TX,     // shifting out a byte
    S_MACK,   // sampling the master's acknowledge
    S_SKIP    // not addressed: ignore until next start
  } bus_st_e;

  function automatic logic [6:0] dev_addr(input bit narrow, input logic [1:0] pins);
    return narrow ? {6'b000110, pins[0]} : {5'b00011, pins};
  endfunction

  function automatic logic [1:0] word_mode(input logic [15:0] w);
    return w[13:12];
  endfunction

  function automatic logic [11:0] word_code12(input logic [15:0] w);
    return w[11:0];
  endfunction

  function automatic logic [15:0] read_word(input logic [1:0] mode, input logic [11:0] code_lj);
    return {2'b00, mode, code_lj};
  endfunction

endpackage

// File: rtl/i2c_dac_sync.sv
module i2c_dac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_pipe[STAGES-1];
  assign sda_lvl = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_dac_link.sv
module i2c_dac_link
  import i2c_dac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_lvl,
  input  logic        sda_lvl,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic [6:0]  my_addr,
  input  logic [15:0] tx_word,
  output logic        sda_oe,
  output logic        rx_valid,
  output logic [7:0]  rx_byte
);
  localparam int BYTE_BITS = 8;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

  bus_st_e    st;
  logic [3:0] bit_cnt;
  logic [7:0] sh, tx_sh, next_tx;
  logic       rd_mode, is_addr, hi_seen, m_ack, tx_hi;
  logic       addr_hit, byte_done;

  assign next_tx   = tx_hi ? tx_word[15:8] : tx_word[7:0];
  assign addr_hit  = (sh[7:1] == my_addr);
  assign byte_done = scl_fall && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      tx_sh    <= '0;
      rd_mode  <= 1'b0;
      is_addr  <= 1'b0;
      hi_seen  <= 1'b0;
      m_ack    <= 1'b0;
      tx_hi    <= 1'b1;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start_det) begin
        st      <= S_RX;
        bit_cnt <= '0;
        is_addr <= 1'b1;
        rd_mode <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_RX: begin
            if (scl_rise) begin
              sh      <= {sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              hi_seen <= 1'b0;
              if (is_addr) begin
                if (addr_hit) begin
                  st      <= S_ACK;
                  sda_oe  <= 1'b1;
                  rd_mode <= sh[0];
                  tx_hi   <= 1'b1;
                end else begin
                  st <= S_SKIP;
                end
              end else begin
                rx_valid <= 1'b1;
                rx_byte  <= sh;
                st       <= S_ACK;
                sda_oe   <= 1'b1;
              end
            end
          end
          S_ACK: begin
            if (scl_rise) begin
              hi_seen <= 1'b1;
            end else if (scl_fall && hi_seen) begin
              is_addr <= 1'b0;
              bit_cnt <= '0;
              if (rd_mode) begin
                st     <= S_TX;
                tx_sh  <= {next_tx[6:0], 1'b0};
                sda_oe <= ~next_tx[7];
                tx_hi  <= ~tx_hi;
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                st      <= S_MACK;
                sda_oe  <= 1'b0;
                hi_seen <= 1'b0;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              hi_seen <= 1'b1;
              m_ack   <= ~sda_lvl;
            end else if (scl_fall && hi_seen) begin
              bit_cnt <= '0;
              if (m_ack) begin
                st     <= S_TX;
                tx_sh  <= {next_tx[6:0], 1'b0};
                sda_oe <= ~next_tx[7];
                tx_hi  <= ~tx_hi;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the pull-down is only switched on while SCL is low
  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R3 / R8: while ignoring the bus the line is left released
  p_skip_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

  // R4: a delivered byte is a single-cycle event
  p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/i2c_dac_regs.sv
module i2c_dac_regs
  import i2c_dac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_clr,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  output logic [DAC_BITS-1:0] dac_code,
  output logic [1:0]          pd_mode,
  output logic                update_stb,
  output logic [15:0]         rd_word
);
  localparam int PAD = 12 - DAC_BITS;

  logic        half;
  logic [7:0]  hi_byte;
  logic [15:0] cmd_word;
  logic [11:0] code_lj;

  assign cmd_word = {hi_byte, rx_byte};
  assign code_lj  = 12'(dac_code) << PAD;
  assign rd_word  = read_word(pd_mode, code_lj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half       <= 1'b0;
      hi_byte    <= '0;
      dac_code   <= '0;
      pd_mode    <= '0;
      update_stb <= 1'b0;
    end else begin
      update_stb <= 1'b0;
      if (frame_clr) begin
        half <= 1'b0;
      end else if (rx_valid) begin
        if (!half) begin
          hi_byte <= rx_byte;
          half    <= 1'b1;
        end else begin
          half       <= 1'b0;
          pd_mode    <= word_mode(cmd_word);
          dac_code   <= DAC_BITS'(word_code12(cmd_word) >> PAD);
          update_stb <= 1'b1;
        end
      end
    end
  end

  // R5: outputs move only together with the strobe
  p_change_with_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_code) || !$stable(pd_mode)) |-> update_stb);

  // R5: the strobe lasts exactly one cycle
  p_stb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !update_stb);

  // R4: an update is always caused by a byte from the link
  p_stb_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |-> $past(rx_valid));

endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
  import i2c_dac_pkg::*;
#(
  parameter int DAC_BITS    = 12,
  parameter bit NARROW_ADDR = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [1:0]          addr_pins,
  output logic [DAC_BITS-1:0] dac_code,
  output logic [1:0]          pd_mode,
  output logic                update_stb
);
  logic        scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic        rx_valid, frame_clr;
  logic [7:0]  rx_byte;
  logic [15:0] rd_word;
  logic [6:0]  my_addr;

  assign my_addr   = dev_addr(NARROW_ADDR, addr_pins);
  assign frame_clr = start_det | stop_det;

  i2c_dac_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_dac_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .my_addr   (my_addr),
    .tx_word   (rd_word),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte)
  );

  i2c_dac_regs #(.DAC_BITS(DAC_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clr  (frame_clr),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .dac_code   (dac_code),
    .pd_mode    (pd_mode),
    .update_stb (update_stb),
    .rd_word    (rd_word)
  );

  // R6: a start or stop never coincides with a committed update input
  p_no_commit_on_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |-> !rx_valid);

endmodule

// File: tb/i2c_dac_slave_bench.sv
module i2c_dac_slave_bench;
  localparam int N = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] pins = 2'b10;
  logic sda_oe, update_stb, sda_line;
  logic [N-1:0] dac_code;
  logic [1:0] pd_mode;

  int total = 0, bad = 0, settle = 0, stb_seen = 0, stb_exp = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_code = '0;
  logic [1:0] exp_pd = '0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_dac_slave #(.DAC_BITS(N)) u_i2c_dac_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(pins), .dac_code(dac_code), .pd_mode(pd_mode), .update_stb(update_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Behavioural model, compared on every clock outside a short settle window
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (update_stb) stb_seen++;
      if (sda_oe && !prev_oe && m_scl) chk(1'b0, "R9 oe rose with SCL high", 1, 0);
      prev_oe = sda_oe;
      if (settle > 0) settle--;
      else begin
        chk(dac_code === exp_code, "R4/R5 dac_code", int'(dac_code), int'(exp_code));
        chk(pd_mode === exp_pd, "R4/R5 pd_mode", int'(pd_mode), int'(exp_pd));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_scl = 1'b0;
  endtask

  // Writes a byte; when commit is set, the model takes word {hi, b}
  task automatic write_byte(input logic [7:0] b, input bit commit, input logic [7:0] hi,
                            output bit acked);
    logic [15:0] w;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    if (commit) begin
      w = {hi, b};
      settle = 12;
      exp_pd = 2'((w >> 12) & 16'h3);
      exp_code = N'((w & 16'h0FFF) >> (12 - N));
      stb_exp++;
    end
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q / 2);
    acked = (sda_line == 1'b0);
    hold(Q - Q / 2);
    m_scl = 1'b0;
    hold(1);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      m_scl = 1'b1; hold(Q / 2);
      b[i] = sda_line;
      hold(Q - Q / 2);
      m_scl = 1'b0;
    end
    hold(1);
    send_bit(give_ack ? 1'b0 : 1'b1);
    hold(1);
    m_sda = 1'b1;
  endtask

  task automatic write_pair(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit a;
    write_byte(hi, 1'b0, 8'h00, a);
    chk(a, {req, " ack first data byte"}, a, 1);
    write_byte(lo, 1'b1, hi, a);
    chk(a, {req, " ack second data byte"}, a, 1);
  endtask

  localparam logic [7:0] AW = 8'h1C;  // address 0001110, write
  localparam logic [7:0] AR = 8'h1D;  // same address, read

  initial begin
    bit a;
    logic [7:0] rb;
    logic [15:0] rw;
    int s0;
    hold(5);
    rst_n = 1'b1;
    hold(2);
    chk(dac_code == '0 && pd_mode == 2'b00, "R1 reset outputs", int'(dac_code), 0);
    chk(!sda_oe && !update_stb, "R1 reset oe/stb", int'({sda_oe, update_stb}), 0);

    // R2, R4: one write with ignored top bits set and low bits set
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    chk(a, "R2 address ack", a, 1);
    write_pair(8'hD5, 8'h5F, "R4");
    bus_stop();
    hold(20);
    chk(stb_seen == stb_exp, "R5 strobe count single", stb_seen, stb_exp);

    // R5: three pairs after one addressing phase
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    write_pair(8'h2F, 8'hFF, "R5");
    write_pair(8'h00, 8'h00, "R5");
    write_pair(8'h3A, 8'hC4, "R5");
    bus_stop();
    hold(20);
    chk(stb_seen == stb_exp, "R5 strobe count repeated", stb_seen, stb_exp);

    // R6: half pair then stop
    s0 = stb_seen;
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    write_byte(8'h1B, 1'b0, 8'h00, a);
    bus_stop();
    hold(20);
    chk(stb_seen == s0, "R6 stop drops half pair", stb_seen, s0);
    // R6: half pair then repeated start, then a fresh pair
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    write_byte(8'h27, 1'b0, 8'h00, a);
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    chk(a, "R6 ack after repeated start", a, 1);
    write_pair(8'h12, 8'h34, "R6");
    bus_stop();
    hold(20);
    chk(stb_seen == s0 + 1, "R6 one update after restart", stb_seen, s0 + 1);

    // R3: wrong address (pins select 10, send 11), data must not land
    s0 = stb_seen;
    bus_start();
    write_byte(8'h1E, 1'b0, 8'h00, a);
    chk(!a, "R3 no ack on mismatch", a, 0);
    write_byte(8'h3F, 1'b0, 8'h00, a);
    chk(!a, "R3 no ack on ignored data", a, 0);
    write_byte(8'hFF, 1'b0, 8'h00, a);
    bus_stop();
    hold(20);
    chk(stb_seen == s0, "R3 no update when unaddressed", stb_seen, s0);

    // R7, R8: read high, low, high again, then NACK
    rw = {2'b00, exp_pd, 12'(16'(exp_code) << (12 - N))};
    bus_start();
    write_byte(AR, 1'b0, 8'h00, a);
    chk(a, "R2 read address ack", a, 1);
    read_byte(1'b1, rb);
    chk(rb == rw[15:8], "R7 read high byte", rb, rw[15:8]);
    read_byte(1'b1, rb);
    chk(rb == rw[7:0], "R7 read low byte", rb, rw[7:0]);
    read_byte(1'b0, rb);
    chk(rb == rw[15:8], "R8 wrap to high byte", rb, rw[15:8]);
    hold(Q);
    chk(!sda_oe, "R8 released after NACK", sda_oe, 0);
    m_scl = 1'b1; hold(Q);
    chk(!sda_oe && sda_line, "R8 line free after NACK", sda_line, 1);
    m_scl = 1'b0; hold(Q);
    bus_stop();
    hold(20);

    // R4: all-ones word with mode 11 after the read
    bus_start();
    write_byte(AW, 1'b0, 8'h00, a);
    write_pair(8'hFF, 8'hFF, "R4");
    bus_stop();
    hold(20);
    chk(pd_mode == 2'b11, "R4 mode field", pd_mode, 3);
    chk(stb_seen == stb_exp, "R5 final strobe count", stb_seen, stb_exp);
    finish_run();
  end

endmodule